// File: doc/BRIEF.md
# OTP Bank Read Controller

This block fetches one bank of a small one-time-programmable array and presents it to software as a group of 32-bit data registers. It holds eight banks of four 32-bit words each. Software writes a bank bit-address, sets a start bit in the control register and polls a sticky done flag in the status register. When the flag is set, it reads the bank's words from a separate data window and then clears the flag by writing 0 to it.

The fetch sequencer reads the bank one word at a time. Before each word it waits a programmable number of clock cycles (the read period), and then it waits the fixed read latency of the array. The words collect in a staging buffer. They are copied into the data window in one step when the last word arrives, so the window shows the previous bank until a new read completes. A behavioural read-only array model with a fixed read latency stands in for the fuse array. Its contents follow a fixed formula. The control bits that belong to fusing, CRC and secure-data loading are plain storage only.

Top module: `otp_bank_reader`

## Requirements
- R1: After reset, the following all read 0: the control register (0x48), the status register (0x4C), the address register (0x50) and every data window word. Both read ports are registered. After a clock edge, ctl_rdata or win_rdata holds the register selected by ctl_raddr or win_raddr at that edge.
- R2: The bank index is bits 9:7 of the address register, which holds a bit address equal to bank times 128. All other address bits are ignored by the fetch. After a read completes, word n of the bank reads at window offset 0x20 + 4n, for n = 0..3.
- R3: Array word i, where i = 4*bank + n, holds ((i+1) * 0x01030507 mod 2^32) XOR 0x5A0000A5. Byte k of the word sits in bits 8k+7:8k.
- R4: Writing control with bit 2 set starts a read when the block is idle. Let P' be the read period (control bits 15:8) and L the array latency (2). Status bit 4 becomes 1 at the edge that falls 1 + 4*(P'+L+1) edges after the edge that sampled the start write.
- R5: A read period of 0 gives the same timing as a period of 1.
- R6: The start bit clears itself when the sequencer accepts the request, so it reads back as 0. The other control fields keep their written values.
- R7: A start written while a read is in progress is ignored. The running read still returns the bank it began with, and no second read follows. The address register still takes the new value.
- R8: The done flag stays set until software writes status with bit 4 = 0. Writing 1 to a status bit never sets it. Status bit 2 (secure-load done) is never set by this block.
- R9: When a read completes in the same cycle as a software write that clears the done flag, the flag ends up set.
- R10: While a new read is in progress, the data window keeps the previous bank's words.
- R11: Control bits 15:8, 5, 4, 3, 1 and 0 read back as written. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Register write strobe |
| ctl_addr | input | 8 | Register write offset |
| ctl_wdata | input | 32 | Register write data |
| ctl_raddr | input | 8 | Register read offset |
| ctl_rdata | output | 32 | Registered register read data |
| win_raddr | input | 8 | Data window read offset |
| win_rdata | output | 32 | Registered data window read data |

## Verification
Two events can fall in the same cycle: the sequencer completing a fetch and setting the done flag, and software clearing that flag with a status write. The bench computes the completion edge from the timing rule of R4. It drives a status write of 0 so that the write is sampled on exactly that edge. It then reads status and expects the flag still set, and checks that a later clear works.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int unsigned NUM_BANKS_D = 8;
  localparam int unsigned WORDS_D     = 4;
  localparam int unsigned WORD_W_D    = 32;
  localparam int unsigned PER_W_D     = 8;
  localparam int unsigned RD_LAT_D    = 2;

  localparam logic [7:0] OFS_WIN  = 8'h20;
  localparam logic [7:0] OFS_CTL  = 8'h48;
  localparam logic [7:0] OFS_STS  = 8'h4C;
  localparam logic [7:0] OFS_ADR  = 8'h50;

  localparam int unsigned CTL_START_BIT = 2;
  localparam int unsigned CTL_PER_LSB   = 8;
  localparam int unsigned STS_DONE_BIT  = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_FETCH = 2'd2
  } seq_state_t;

  function automatic logic [31:0] otp_fill(int unsigned idx);
    logic [31:0] k;
    k = 32'(idx + 1);
    return (k * 32'h01030507) ^ 32'h5A0000A5;
  endfunction

endpackage

// File: rtl/otp_array_model.sv
module otp_array_model
  import otp_pkg::*;
#(
  parameter int unsigned DEPTH = NUM_BANKS_D * WORDS_D,
  parameter int unsigned DW    = WORD_W_D,
  parameter int unsigned LAT   = RD_LAT_D,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] rom [DEPTH];
  logic [DW-1:0] dq  [LAT];
  logic [LAT-1:0] vq;

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = otp_fill(i);
  end

  always_ff @(posedge clk) begin
    if (rd_en) dq[0] <= rom[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) vq[0] <= 1'b0;
    else     vq[0] <= rd_en;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_pipe
    always_ff @(posedge clk) begin
      dq[s] <= dq[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) vq[s] <= 1'b0;
      else     vq[s] <= vq[s-1];
    end
  end

  assign rd_valid = vq[LAT-1];
  assign rd_data  = dq[LAT-1];

endmodule

// File: rtl/otp_period_timer.sv
module otp_period_timer
  import otp_pkg::*;
#(
  parameter int unsigned PER_W = PER_W_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PER_W-1:0] period,
  output logic             expire
);

  logic [PER_W-1:0] cnt;
  logic             running;
  logic [PER_W-1:0] eff;

  assign eff    = (period == '0) ? PER_W'(1) : period;
  assign expire = running && (cnt == PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= eff;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == PER_W'(1)) running <= 1'b0;
      else                  cnt     <= cnt - PER_W'(1);
    end
  end

  AST_TIMER_NONZERO: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt != '0)); // R5

endmodule

// File: rtl/otp_fetch_seq.sv
module otp_fetch_seq
  import otp_pkg::*;
#(
  parameter int unsigned NUM_BANKS = NUM_BANKS_D,
  parameter int unsigned WORDS     = WORDS_D,
  parameter int unsigned DW        = WORD_W_D,
  parameter int unsigned PER_W     = PER_W_D,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned WIDX_W   = $clog2(WORDS),
  localparam int unsigned AW       = BANK_W + WIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BANK_W-1:0] bank,
  input  logic [PER_W-1:0]  period,
  output logic              accept,
  output logic              busy,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic              arr_valid,
  input  logic [DW-1:0]     arr_data,
  output logic              commit,
  output logic [WORDS*DW-1:0] win_flat
);

  seq_state_t        state;
  logic [WIDX_W-1:0] widx;
  logic [BANK_W-1:0] bank_q;
  logic [PER_W-1:0]  per_q;
  logic              latch;
  logic              last;
  logic              expire;
  logic              tmr_load;
  logic [PER_W-1:0]  tmr_period;
  logic [DW-1:0]     stage [WORDS];
  logic [DW-1:0]     win   [WORDS];

  assign busy       = (state != SEQ_IDLE);
  assign accept     = (state == SEQ_IDLE) && start;
  assign latch      = (state == SEQ_FETCH) && arr_valid;
  assign last       = (widx == WIDX_W'(WORDS - 1));
  assign commit     = latch && last;
  assign tmr_load   = accept || (latch && !last);
  assign tmr_period = accept ? period : per_q;

  otp_period_timer #(.PER_W(PER_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .period (tmr_period),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      widx    <= '0;
      bank_q  <= '0;
      per_q   <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_en <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state  <= SEQ_WAIT;
            widx   <= '0;
            bank_q <= bank;
            per_q  <= period;
          end
        end
        SEQ_WAIT: begin
          if (expire) begin
            state   <= SEQ_FETCH;
            rd_en   <= 1'b1;
            rd_addr <= {bank_q, widx};
          end
        end
        SEQ_FETCH: begin
          if (arr_valid) begin
            if (last) begin
              state <= SEQ_IDLE;
            end else begin
              state <= SEQ_WAIT;
              widx  <= widx + WIDX_W'(1);
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (latch) stage[widx] <= arr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) win[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < WORDS - 1; i++) win[i] <= stage[i];
      win[WORDS-1] <= arr_data;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign win_flat[g*DW +: DW] = win[g];
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en); // R4

  AST_VALID_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    arr_valid |-> (state == SEQ_FETCH)); // R4

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(win_flat)); // R10

endmodule

// File: rtl/otp_bank_reader.sv
module otp_bank_reader
  import otp_pkg::*;
#(
  parameter int unsigned NUM_BANKS = NUM_BANKS_D,
  parameter int unsigned WORDS     = WORDS_D,
  parameter int unsigned PER_W     = PER_W_D,
  parameter int unsigned RD_LAT    = RD_LAT_D,
  localparam int unsigned DW       = WORD_W_D,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned WIDX_W   = $clog2(WORDS),
  localparam int unsigned AW       = BANK_W + WIDX_W,
  localparam int unsigned BANK_LSB = $clog2(WORDS * DW)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_addr,
  input  logic [31:0] ctl_wdata,
  input  logic [7:0]  ctl_raddr,
  output logic [31:0] ctl_rdata,
  input  logic [7:0]  win_raddr,
  output logic [31:0] win_rdata
);

  logic [PER_W-1:0] per_q;
  logic [2:0]       keep_hi;
  logic [1:0]       keep_lo;
  logic             start_q;
  logic             done_q;
  logic [31:0]      addr_q;

  logic             ctl_wr, sts_wr, adr_wr, ctl_start_wr;
  logic             accept, busy, commit;
  logic             rd_en, arr_valid;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    arr_data;
  logic [WORDS*DW-1:0] win_flat;

  assign ctl_wr       = ctl_we && (ctl_addr == OFS_CTL);
  assign sts_wr       = ctl_we && (ctl_addr == OFS_STS);
  assign adr_wr       = ctl_we && (ctl_addr == OFS_ADR);
  assign ctl_start_wr = ctl_wr && ctl_wdata[CTL_START_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= '0;
      keep_hi <= '0;
      keep_lo <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (ctl_wr) begin
        per_q   <= ctl_wdata[CTL_PER_LSB +: PER_W];
        keep_hi <= ctl_wdata[5:3];
        keep_lo <= ctl_wdata[1:0];
      end
      if (ctl_start_wr && !busy) start_q <= 1'b1;
      else if (accept)           start_q <= 1'b0;
      if (commit)      done_q <= 1'b1;
      else if (sts_wr) done_q <= done_q & ctl_wdata[STS_DONE_BIT];
      if (adr_wr) addr_q <= ctl_wdata;
    end
  end

  otp_fetch_seq #(
    .NUM_BANKS (NUM_BANKS),
    .WORDS     (WORDS),
    .DW        (DW),
    .PER_W     (PER_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_q),
    .bank      (addr_q[BANK_LSB +: BANK_W]),
    .period    (per_q),
    .accept    (accept),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .arr_valid (arr_valid),
    .arr_data  (arr_data),
    .commit    (commit),
    .win_flat  (win_flat)
  );

  otp_array_model #(
    .DEPTH (NUM_BANKS * WORDS),
    .DW    (DW),
    .LAT   (RD_LAT)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (arr_valid),
    .rd_data  (arr_data)
  );

  logic [31:0] ctl_view;
  logic [31:0] sts_view;
  logic [7:0]  woff;
  logic        win_hit;

  always_comb begin
    ctl_view = '0;
    ctl_view[CTL_PER_LSB +: PER_W] = per_q;
    ctl_view[5:3]                  = keep_hi;
    ctl_view[CTL_START_BIT]        = start_q;
    ctl_view[1:0]                  = keep_lo;
    sts_view = '0;
    sts_view[STS_DONE_BIT] = done_q;
  end

  assign woff    = win_raddr - OFS_WIN;
  assign win_hit = (win_raddr >= OFS_WIN) && (woff < 8'(4 * WORDS)) && (woff[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rdata <= '0;
      win_rdata <= '0;
    end else begin
      case (ctl_raddr)
        OFS_CTL: ctl_rdata <= ctl_view;
        OFS_STS: ctl_rdata <= sts_view;
        OFS_ADR: ctl_rdata <= addr_q;
        default: ctl_rdata <= '0;
      endcase
      if (win_hit) win_rdata <= win_flat[woff[2 +: WIDX_W]*DW +: DW];
      else         win_rdata <= '0;
    end
  end

  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (accept && !ctl_start_wr) |=> !start_q); // R6

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && !start_q && ctl_start_wr) |=> !start_q); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(sts_wr && !ctl_wdata[STS_DONE_BIT])) |=> done_q); // R8

  AST_DONE_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    commit |=> done_q); // R9

endmodule

// File: tb/test_otp_bank_reader.sv
`timescale 1ns/1ps
module test_otp_bank_reader;

  localparam int RD_LAT = 2;
  localparam logic [7:0] A_WIN = 8'h20;
  localparam logic [7:0] A_CTL = 8'h48;
  localparam logic [7:0] A_STS = 8'h4C;
  localparam logic [7:0] A_ADR = 8'h50;

  // {bank[2:0], low address bits[6:0], period[7:0]}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {3'd0, 7'd0,   8'd30},
    {3'd7, 7'd127, 8'd1},
    {3'd3, 7'd5,   8'd0},
    {3'd5, 7'd64,  8'd2},
    {3'd1, 7'd1,   8'd255},
    {3'd6, 7'd99,  8'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_addr = '0;
  logic [31:0] ctl_wdata = '0;
  logic [7:0]  ctl_raddr = '0;
  logic [31:0] ctl_rdata;
  logic [7:0]  win_raddr = '0;
  logic [31:0] win_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  otp_bank_reader i_otp_bank_reader (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_addr  (ctl_addr),
    .ctl_wdata (ctl_wdata),
    .ctl_raddr (ctl_raddr),
    .ctl_rdata (ctl_rdata),
    .win_raddr (win_raddr),
    .win_rdata (win_rdata)
  );

  function automatic logic [31:0] exp_word(int b, int n);
    logic [31:0] k;
    k = 32'(b * 4 + n + 1);
    return (k * 32'h01030507) ^ 32'h5A0000A5;
  endfunction

  function automatic int exp_cycles(int per);
    int e;
    e = (per == 0) ? 1 : per;
    return 2 + 4 * (e + RD_LAT + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
    @(posedge clk); @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic rd_ctl(logic [7:0] a, output logic [31:0] v);
    ctl_raddr = a;
    @(posedge clk); @(negedge clk);
    v = ctl_rdata;
  endtask

  task automatic rd_win(int n, output logic [31:0] v);
    win_raddr = A_WIN + 8'(4 * n);
    @(posedge clk); @(negedge clk);
    v = win_rdata;
  endtask

  task automatic start_read(int bank, int low, int per);
    wr(A_ADR, 32'(bank * 128 + low));
    wr(A_STS, 32'h0);
    ctl_raddr = A_STS;
    ctl_we = 1'b1; ctl_addr = A_CTL; ctl_wdata = 32'(per << 8) | 32'h4;
    @(posedge clk); @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic poll_done(output int c);
    c = 0;
    ctl_raddr = A_STS;
    forever begin
      @(posedge clk); c++; @(negedge clk);
      if (ctl_rdata[4] || c > 5000) break;
    end
  endtask

  task automatic check_bank(string tag, int bank);
    logic [31:0] v;
    for (int n = 0; n < 4; n++) begin
      rd_win(n, v);
      chk(tag, v, exp_word(bank, n));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_ctl(A_CTL, v); chk("R1 ctl", v, 32'h0);
    rd_ctl(A_STS, v); chk("R1 sts", v, 32'h0);
    rd_ctl(A_ADR, v); chk("R1 adr", v, 32'h0);
    for (int n = 0; n < 4; n++) begin
      rd_win(n, v); chk("R1 window", v, 32'h0);
    end

    // R11 storage bits
    wr(A_CTL, 32'hFFFF_FFFB);
    rd_ctl(A_CTL, v); chk("R11 ctl storage", v, 32'h0000_FF3B);
    wr(A_CTL, 32'h0);
    rd_ctl(A_CTL, v); chk("R11 ctl cleared", v, 32'h0);

    // R8 writing ones to status sets nothing
    wr(A_STS, 32'hFFFF_FFFF);
    rd_ctl(A_STS, v); chk("R8 sts write ones", v, 32'h0);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      int b, lo, pr;
      b  = int'(VEC[i][17:15]);
      lo = int'(VEC[i][14:8]);
      pr = int'(VEC[i][7:0]);
      start_read(b, lo, pr);
      poll_done(c);
      chk((pr == 0) ? "R5 zero period timing" : "R4 done timing",
          32'(c), 32'(exp_cycles(pr)));
      check_bank("R2 R3 bank words", b);
      rd_ctl(A_CTL, v); chk("R6 start self-clear", v, 32'(pr << 8));
    end

    // R8 sticky: write of one keeps flag, write of zero clears
    wr(A_STS, 32'hFFFF_FFFF);
    rd_ctl(A_STS, v); chk("R8 done sticky", v, 32'h10);
    wr(A_STS, 32'hFFFF_FFEF);
    rd_ctl(A_STS, v); chk("R8 done cleared", v, 32'h0);

    // R9 clear collides with completion: period 3, completion 25 edges after start edge
    start_read(4, 0, 3);
    repeat (24) @(posedge clk);
    @(negedge clk);
    wr(A_STS, 32'h0);
    rd_ctl(A_STS, v); chk("R9 set wins over clear", v, 32'h10);
    check_bank("R9 bank words", 4);
    wr(A_STS, 32'h0);
    rd_ctl(A_STS, v); chk("R9 later clear", v, 32'h0);

    // R7 start during busy is ignored
    start_read(1, 0, 4);
    repeat (5) @(posedge clk);
    @(negedge clk);
    wr(A_ADR, 32'h0000_0300);
    wr(A_CTL, 32'h0000_0404);
    poll_done(c);
    chk("R7 first read done", 32'(ctl_rdata[4]), 32'h1);
    check_bank("R7 bank kept", 1);
    rd_ctl(A_ADR, v); chk("R7 address updated", v, 32'h300);
    rd_ctl(A_CTL, v); chk("R7 start bit clear", v, 32'h0000_0400);
    wr(A_STS, 32'h0);
    repeat (100) @(posedge clk);
    @(negedge clk);
    rd_ctl(A_STS, v); chk("R7 no second read", v, 32'h0);

    // R10 window holds previous bank during a new read
    start_read(2, 0, 1);
    poll_done(c);
    check_bank("R10 first bank", 2);
    start_read(5, 0, 20);
    repeat (30) @(posedge clk);
    @(negedge clk);
    check_bank("R10 window held", 2);
    poll_done(c);
    chk("R10 second read done", 32'(ctl_rdata[4]), 32'h1);
    check_bank("R10 window updated", 5);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule